// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits inside a clock generator and derives four output clock waveforms from a single fast master clock. It makes a CPU clock and an SDRAM clock at half the master rate, and two PCI clocks at a quarter of the master rate. One PCI clock can be gated. The other always runs. Three active-low power-management requests control the outputs. A CPU-stop request parks the CPU clock low. A PCI-stop request parks only the gated PCI clock. A power-down request drains every output to low, turns off the oscillator/PLL enable, and tells the configuration logic to hold its registers and detach from the serial programming bus.

Every gate changes state only while its output is low, so a stop or a restart never produces a shortened pulse. The power-down request is asynchronous, so it passes through a synchronizer first. The stop requests are synchronous. All three requests are honoured only while the mode select is 0. When power-down ends, the block waits a fixed settle interval with all outputs low. The dividers then restart from a known phase. If draining the outputs takes longer than a configured budget, a sticky error flag is raised.

Top module: `clkpm_ctrl`

## Requirements
- R1: While running, the CPU and SDRAM outputs are high for exactly one master cycle and low for one. The two PCI outputs are high for two master cycles and low for two. Every high pulse on any output has full width.
- R2: The gated PCI output is high only in cycles where the free-running PCI output is also high, so the two stay phase-aligned.
- R3: With mode 0 and the CPU-stop request low, the CPU output is held low within two master edges. The SDRAM and both PCI outputs keep toggling.
- R4: After the CPU-stop request is released, the CPU output produces no rising edge for at least 6 master cycles (3 CPU periods). It then resumes toggling.
- R5: With mode 0 and the PCI-stop request low, the gated PCI output is held low. The free-running PCI and CPU outputs keep toggling.
- R6: With mode 0 and the power-down request low, all four outputs go low after their current cycle. The oscillator/PLL enable then drops to 0, and all outputs stay low while it is 0.
- R7: The register-hold flag is 1 whenever the block is not in normal running, including out of reset, during power-down and during the settle interval. In particular it is 1 whenever the oscillator enable is 0.
- R8: The error flag is 0 after reset. It becomes 1 if the drain phase of a power-down lasts PD_MAX_CYC master cycles or more. Once set, it stays 1 until reset.
- R9: With mode 1, all three requests are ignored: every output toggles and the oscillator enable stays 1.
- R10: After power-down ends, all outputs stay low for SETTLE_CYC master cycles after the oscillator enable returns. The first CPU rising edge comes SETTLE_CYC+1 cycles after the enable returns, and the free-running PCI output rises one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | 0 = power-management requests honoured, 1 = requests ignored |
| pd_req_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Synchronous active-low CPU clock stop request |
| pci_stop_n | input | 1 | Synchronous active-low gated-PCI clock stop request |
| cpu_clk | output | 1 | CPU clock output, master/2 |
| sdram_clk | output | 1 | SDRAM clock output, master/2 |
| pci_clk | output | 1 | Gated PCI clock output, master/4 |
| pci_free_clk | output | 1 | Free-running PCI clock output, master/4 |
| osc_en | output | 1 | Oscillator/PLL enable, 0 while powered down |
| cfg_hold | output | 1 | Configuration registers held, serial bus detached |
| pd_err | output | 1 | Sticky flag: power-down drain exceeded its budget |

## Verification
The hardest situation to reach is the exit from power-down. It requires a full drain, the synchronizer delay, a stay in the powered-down state and the settle interval, all before the restart phase can be observed. A directed sequence drives the request low, waits for the enable to drop, releases the request, and then counts cycles from the returning enable to the first CPU and PCI rising edges. The drain-budget error cannot occur with the default budget, so a second instance with a zero budget is driven in parallel. Randomly timed combinations of mode changes, stops and power-downs then run while pulse widths, alignment and stop behaviour are checked on every cycle.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_DOWN   = 2'd2,
        ST_SETTLE = 2'd3
    } pm_state_e;

    localparam int GATE_CPU   = 0;
    localparam int GATE_SDRAM = 1;
    localparam int GATE_PCI   = 2;
    localparam int GATE_FREE  = 3;
    localparam int NUM_GATES  = 4;
endpackage

// File: rtl/clkpm_sync.sv
module clkpm_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkpm_gate.sv
module clkpm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_nxt,
    input  logic want,
    output logic en,
    output logic clk_out
);
    logic en_d, en_q, out_d, out_q;

    always_comb begin
        // enable may only change where the output will be low anyway
        en_d  = raw_nxt ? en_q : want;
        out_d = raw_nxt & en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            out_q <= 1'b0;
        end else begin
            en_q  <= en_d;
            out_q <= out_d;
        end
    end

    assign en      = en_q;
    assign clk_out = out_q;
endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
    import clkpm_pkg::*;
#(
    parameter int SETTLE_CYC      = 8,
    parameter int CPU_RESTART_PER = 3,
    parameter int PD_MAX_CYC      = 16,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic pd_req_n,
    input  logic cpu_stop_n,
    input  logic pci_stop_n,
    output logic cpu_clk,
    output logic sdram_clk,
    output logic pci_clk,
    output logic pci_free_clk,
    output logic osc_en,
    output logic cfg_hold,
    output logic pd_err
);
    localparam int RESTART_CYC = 2 * CPU_RESTART_PER;
    localparam int RW = $clog2(RESTART_CYC + 1);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int DW = $clog2(PD_MAX_CYC + 2);
    localparam logic [RW-1:0] RMAX  = RW'(RESTART_CYC);
    localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);
    localparam logic [DW-1:0] DMAX  = DW'(PD_MAX_CYC);
    localparam logic [DW-1:0] DSAT  = {DW{1'b1}};

    typedef struct packed {
        pm_state_e     state;
        logic [1:0]    ph;
        logic [SW-1:0] settle;
        logic [RW-1:0] restart;
        logic [DW-1:0] drain;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;
    logic  pd_sync;
    logic  pd_act, cpu_stop, pci_stop, run_nxt;
    logic [NUM_GATES-1:0] raw_nxt, want, gate_en, gate_out;

    clkpm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pd_req_n),
        .q     (pd_sync)
    );

    always_comb begin
        pd_act   = ~pd_sync    & ~mode_sel;
        cpu_stop = ~cpu_stop_n & ~mode_sel;
        pci_stop = ~pci_stop_n & ~mode_sel;
        r_d      = r_q;

        unique case (r_q.state)
            ST_RUN: begin
                if (pd_act) begin
                    r_d.state = ST_DRAIN;
                    r_d.drain = '0;
                end
            end
            ST_DRAIN: begin
                if (r_q.drain >= DMAX) r_d.err = 1'b1;
                if (gate_en == '0)     r_d.state = ST_DOWN;
                else if (r_q.drain != DSAT) r_d.drain = r_q.drain + 1'b1;
            end
            ST_DOWN: begin
                if (!pd_act) begin
                    r_d.state  = ST_SETTLE;
                    r_d.settle = '0;
                end
            end
            default: begin
                if (r_q.settle == SLAST) r_d.state = ST_RUN;
                else                     r_d.settle = r_q.settle + 1'b1;
            end
        endcase

        // dividers held at a known phase while stopped or settling
        if (r_q.state == ST_DOWN || r_q.state == ST_SETTLE) r_d.ph = 2'd0;
        else                                                r_d.ph = r_q.ph + 2'd1;

        if (cpu_stop)               r_d.restart = '0;
        else if (r_q.restart != RMAX) r_d.restart = r_q.restart + 1'b1;

        run_nxt = (r_d.state == ST_RUN);
        raw_nxt[GATE_CPU]   = r_d.ph[0];
        raw_nxt[GATE_SDRAM] = r_d.ph[0];
        raw_nxt[GATE_PCI]   = r_d.ph[1];
        raw_nxt[GATE_FREE]  = r_d.ph[1];
        want[GATE_CPU]      = run_nxt & ~cpu_stop & (r_d.restart == RMAX);
        want[GATE_SDRAM]    = run_nxt;
        want[GATE_PCI]      = run_nxt & ~pci_stop;
        want[GATE_FREE]     = run_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_SETTLE;
            r_q.ph      <= 2'd0;
            r_q.settle  <= '0;
            r_q.restart <= RMAX;
            r_q.drain   <= '0;
            r_q.err     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        clkpm_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_nxt (raw_nxt[g]),
            .want    (want[g]),
            .en      (gate_en[g]),
            .clk_out (gate_out[g])
        );
    end

    assign cpu_clk      = gate_out[GATE_CPU];
    assign sdram_clk    = gate_out[GATE_SDRAM];
    assign pci_clk      = gate_out[GATE_PCI];
    assign pci_free_clk = gate_out[GATE_FREE];
    assign osc_en       = (r_q.state != ST_DOWN);
    assign cfg_hold     = (r_q.state != ST_RUN);
    assign pd_err       = r_q.err;
endmodule

// File: rtl/clkpm_ctrl_chk.sv
module clkpm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_sel,
    input logic cpu_stop_n,
    input logic cpu_clk,
    input logic sdram_clk,
    input logic pci_clk,
    input logic pci_free_clk,
    input logic osc_en,
    input logic cfg_hold,
    input logic pd_err
);
    AST_CPU_HALF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk |=> !cpu_clk); // R1
    AST_SDRAM_HALF_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        sdram_clk |=> !sdram_clk); // R1
    AST_PCI_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pci_clk |-> pci_free_clk); // R2
    AST_CPU_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!mode_sel && !cpu_stop_n) && $past(!mode_sel && !cpu_stop_n, 2))
        |-> !cpu_clk); // R3
    AST_OFF_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !(cpu_clk || sdram_clk || pci_clk || pci_free_clk)); // R6
    AST_OFF_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> cfg_hold); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pd_err |=> pd_err); // R8
endmodule

bind clkpm_ctrl clkpm_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .cpu_stop_n   (cpu_stop_n),
    .cpu_clk      (cpu_clk),
    .sdram_clk    (sdram_clk),
    .pci_clk      (pci_clk),
    .pci_free_clk (pci_free_clk),
    .osc_en       (osc_en),
    .cfg_hold     (cfg_hold),
    .pd_err       (pd_err)
);

// File: tb/tb_clkpm_ctrl.sv
module tb_clkpm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_sel = 1'b0, pd_req_n = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1;
    logic cpu_clk, sdram_clk, pci_clk, pci_free_clk, osc_en, cfg_hold, pd_err;
    logic t_cpu, t_sdram, t_pci, t_free, t_osc, t_hold, t_err;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int hi_len[4], since_rise[4], rises[4];
    logic prev[4];
    int stop_age = 0, mode1_age = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkpm_ctrl #(.SETTLE_CYC(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pd_req_n(pd_req_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .cpu_clk(cpu_clk),
        .sdram_clk(sdram_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk),
        .osc_en(osc_en), .cfg_hold(cfg_hold), .pd_err(pd_err));

    clkpm_ctrl #(.SETTLE_CYC(SETTLE), .PD_MAX_CYC(0)) dut_tight (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pd_req_n(pd_req_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .cpu_clk(t_cpu),
        .sdram_clk(t_sdram), .pci_clk(t_pci), .pci_free_clk(t_free),
        .osc_en(t_osc), .cfg_hold(t_hold), .pd_err(t_err));

    function automatic int exp_high_len(int idx);
        return (idx < 2) ? 1 : 2;
    endfunction

    function automatic int exp_rises(int idx, int n);
        return (idx < 2) ? n / 2 : n / 4;
    endfunction

    function automatic logic get_out(int idx);
        case (idx)
            0: return cpu_clk;
            1: return sdram_clk;
            2: return pci_clk;
            default: return pci_free_clk;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic count_rises(int n);
        logic p[4];
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin p[i] = get_out(i); rises[i] = 0; end
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (get_out(i) && !p[i]) rises[i]++;
                p[i] = get_out(i);
            end
        end
    endtask

    // continuous monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 4; i++) begin
                logic o;
                o = get_out(i);
                if (o) hi_len[i]++;
                else if (prev[i]) begin
                    chk(hi_len[i] == exp_high_len(i), "R1", hi_len[i], exp_high_len(i));
                    hi_len[i] = 0;
                end
                if (o && !prev[i]) since_rise[i] = 0;
                else if (since_rise[i] < 1000) since_rise[i]++;
                prev[i] = o;
            end
            if (pci_clk) chk(pci_free_clk == 1'b1, "R2", pci_free_clk, 1);
            if (!mode_sel && !cpu_stop_n) stop_age++; else stop_age = 0;
            if (stop_age >= 4) chk(cpu_clk == 1'b0, "R3", cpu_clk, 0);
            if (mode_sel) mode1_age++; else mode1_age = 0;
            if (mode1_age >= 20) begin
                for (int i = 0; i < 4; i++) chk(since_rise[i] <= 4, "R9", since_rise[i], 4);
                chk(osc_en == 1'b1, "R9", osc_en, 1);
            end
            if (!osc_en) chk(cfg_hold && !(cpu_clk | sdram_clk | pci_clk | pci_free_clk),
                             "R7", {cfg_hold, cpu_clk, sdram_clk, pci_clk, pci_free_clk}, 16);
        end
    end

    initial begin
        int lows;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin hi_len[i] = 0; since_rise[i] = 1000; prev[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(!(cpu_clk | sdram_clk | pci_clk | pci_free_clk), "R6", cpu_clk, 0);
        chk(osc_en == 1'b1, "R6", osc_en, 1);
        chk(cfg_hold == 1'b1, "R7", cfg_hold, 1);
        chk(pd_err == 1'b0 && t_err == 1'b0, "R8", t_err, 0);
        step(30);

        count_rises(16);
        for (int i = 0; i < 4; i++) chk(rises[i] == exp_rises(i, 16), "R1", rises[i], exp_rises(i, 16));

        cpu_stop_n = 1'b0; step(4);
        count_rises(16);
        chk(rises[0] == 0, "R3", rises[0], 0);
        chk(rises[1] == 8, "R3", rises[1], 8);
        chk(rises[3] == 4, "R3", rises[3], 4);

        @(posedge clk); #2 cpu_stop_n = 1'b1;
        lows = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (cpu_clk) break;
            lows++;
        end
        chk(lows >= 7 && lows <= 10, "R4", lows, 7);
        step(4);
        count_rises(16);
        chk(rises[0] == 8, "R4", rises[0], 8);

        pci_stop_n = 1'b0; step(5);
        count_rises(16);
        chk(rises[2] == 0, "R5", rises[2], 0);
        chk(rises[3] == 4, "R5", rises[3], 4);
        chk(rises[0] == 8, "R5", rises[0], 8);
        pci_stop_n = 1'b1; step(6);
        count_rises(16);
        chk(rises[2] == 4, "R5", rises[2], 4);

        mode_sel = 1'b1; step(1);
        cpu_stop_n = 1'b0; pci_stop_n = 1'b0; pd_req_n = 1'b0; step(6);
        count_rises(16);
        for (int i = 0; i < 4; i++) chk(rises[i] == exp_rises(i, 16), "R9", rises[i], exp_rises(i, 16));
        chk(osc_en == 1'b1 && cfg_hold == 1'b0, "R9", osc_en, 1);
        cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pd_req_n = 1'b1; step(1);
        mode_sel = 1'b0; step(12);

        pd_req_n = 1'b0; step(12);
        @(negedge clk);
        chk(osc_en == 1'b0, "R6", osc_en, 0);
        chk(!(cpu_clk | sdram_clk | pci_clk | pci_free_clk), "R6", cpu_clk, 0);
        chk(cfg_hold == 1'b1, "R7", cfg_hold, 1);
        chk(pd_err == 1'b0, "R8", pd_err, 0);
        chk(t_err == 1'b1, "R8", t_err, 1);

        @(posedge clk); #2 pd_req_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (osc_en) break;
        end
        lows = 1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (cpu_clk) break;
            chk(!(sdram_clk | pci_clk | pci_free_clk), "R10", sdram_clk, 0);
            lows++;
        end
        chk(lows == SETTLE + 1, "R10", lows, SETTLE + 1);
        @(negedge clk);
        chk(pci_free_clk == 1'b1 && cpu_clk == 1'b0, "R10", pci_free_clk, 1);
        chk(t_err == 1'b1, "R8", t_err, 1);

        for (int s = 0; s < 250; s++) begin
            mode_sel   = ($urandom % 4) == 0;
            cpu_stop_n = $urandom % 2;
            pci_stop_n = $urandom % 2;
            pd_req_n   = ($urandom % 8) != 0;
            step(1 + $urandom % 30);
        end
        mode_sel = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pd_req_n = 1'b1;
        step(40);
        count_rises(16);
        for (int i = 0; i < 4; i++) chk(rises[i] == exp_rises(i, 16), "R1", rises[i], exp_rises(i, 16));
        chk(pd_err == 1'b0, "R8", pd_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule